// File: doc/BRIEF.md
# Isochronous Video Packet Header Generator

This block turns a buffered video byte stream into the payloads of isochronous IN packets. Each time the USB engine grants a packet slot (a one-cycle request), the block decides whether to answer with a zero-length response, a one-byte drop packet, or a data packet. It then emits that packet as a byte stream, one byte per clock, with start and end markers.

A data packet always begins with a header. The first packet of a video frame carries a ten-byte header: a sequence byte followed by nine property bytes that describe the frame. Every later packet of the same frame carries only the sequence byte. The sequence byte restarts at zero on each frame and counts packets, skipping the value reserved for drop packets.

The FIFO in front of the block is show-ahead. The block sees the head byte, a flag telling whether that byte closes a frame, and the number of bytes held, and it pops bytes as it sends them. The maximum packet size follows the current alternate setting, and header bytes count toward it.

Top module: `iso_pkt_hdr_gen`

## Requirements
- R1: In the first packet of a frame, bytes 1 to 9 after the sequence byte are property bytes 1 to 9. Byte 1 is `prop_info[7:0]` with bit 5 forced to 0, so bits [4:0] hold the image type, bit 6 the snap flag and bit 7 the snap policy. Bytes 2 to 5 are `prop_info[15:8]`, `[23:16]`, `[31:24]` and `[39:32]`. Byte 6 is the frame count. Bytes 7 to 9 are `prop_info[47:40]`, `[55:48]` and `[63:56]`.
- R2: Every later packet of a frame has a one-byte header (the sequence byte), followed directly by frame data.
- R3: The sequence byte is 0x00 in the first packet of a frame. It rises by one with each later data packet of that frame, and after 0xFE the next value is 0x00.
- R4: When `drop_block` is 0 and the FIFO holds at most 4 bytes (`drop_thr_sel`=0) or at most 1 byte (`drop_thr_sel`=1), the packet is a single byte 0xFF carrying both start and end markers. It pops nothing and leaves the sequence unchanged.
- R5: With `drop_block`=1 no drop packet is sent. With an empty FIFO the packet consists of its header only.
- R6: The maximum packet size, header included, is 0, 128, 384, 512, 640, 768, 896 or 1023 bytes for `alt_set` 0 to 7. A packet whose FIFO and frame hold enough data is exactly that long.
- R7: A packet ends with the byte flagged as last of its frame. The next data packet starts a new frame.
- R8: With `alt_set`=0 a request produces a one-cycle `pkt_zlp` pulse, no bytes and no pop.
- R9: While `iso_en`=0, requests produce no output, no pop and no change to the sequence state.
- R10: Property byte 6 equals the number of `frame_tick` pulses since reset, modulo 256, taken when the packet starts.
- R11: After reset no output is active. The first byte (or the `pkt_zlp` pulse) appears in the cycle after the request edge, bytes follow one per cycle, requests seen while a packet is in progress are ignored, and the cycle after the end marker is idle.
- R12: A data packet also ends when the FIFO runs out of bytes.

State machine: IDLE waits for a request and goes to EMPTY (alternate setting 0), DROP (low fill level) or HDR (otherwise). HDR steps through the header and goes to BODY when data is available, or back to IDLE when the FIFO is empty. BODY returns to IDLE on frame end, on reaching the size limit, or when the FIFO is drained. DROP and EMPTY last one cycle and return to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iso_en | input | 1 | Packet generation enable |
| drop_block | input | 1 | Suppress drop packets |
| drop_thr_sel | input | 1 | Drop threshold: 0 = at most 4 bytes, 1 = at most 1 byte |
| alt_set | input | 3 | Alternate setting selecting the maximum packet size |
| pkt_req | input | 1 | One-cycle packet slot request from the USB engine |
| frame_tick | input | 1 | Input frame pulse for the frame counter |
| prop_info | input | 64 | Property bytes 1 to 5 and 7 to 9, packed low to high |
| fifo_level | input | FILL_W | Bytes held in the FIFO |
| fifo_data | input | 8 | FIFO head byte |
| fifo_last | input | 1 | Head byte closes a frame |
| fifo_pop | output | 1 | Consume the head byte at this edge |
| pkt_valid | output | 1 | `pkt_byte` is valid |
| pkt_byte | output | 8 | Packet byte |
| pkt_sop | output | 1 | First byte of a packet |
| pkt_eop | output | 1 | Last byte of a packet |
| pkt_zlp | output | 1 | Zero-length response |

## Verification
A request is accepted at one rising edge, and the first packet byte or the zero-length pulse is due in the very next cycle. Every following byte comes one cycle later, and the FIFO pop that supplies a data byte takes effect at the edge that ends that byte's cycle. The bench raises the request on a falling edge and samples the first result on the next falling edge. After that it samples once per falling edge until the end marker, then samples one more falling edge to confirm the idle cycle. The expected bytes, length and kind of each packet are computed by bench functions from the fill level, settings and FIFO content present at the moment of the request.

// File: rtl/iso_hdr_pkg.sv
package iso_hdr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HDR   = 3'd1,
        ST_BODY  = 3'd2,
        ST_DROP  = 3'd3,
        ST_EMPTY = 3'd4
    } pkt_state_t;

    localparam int          HDR_BYTES  = 10;
    localparam int          PROP_BYTES = 8;
    localparam int          SIZE_W     = 11;
    localparam logic [7:0]  SEQ_LAST   = 8'hFE;
    localparam logic [7:0]  DROP_MARK  = 8'hFF;
    localparam logic [7:0]  PROP1_MASK = 8'hDF;

    function automatic logic [SIZE_W-1:0] alt_max_size(input logic [2:0] alt);
        logic [SIZE_W-1:0] sz;
        unique case (alt)
            3'd0:    sz = '0;
            3'd1:    sz = SIZE_W'(128);
            3'd7:    sz = SIZE_W'(1023);
            default: sz = SIZE_W'(({8'd0, alt} + 11'd1) << 7);
        endcase
        return sz;
    endfunction

endpackage

// File: rtl/iso_pkt_seq.sv
module iso_pkt_seq
    import iso_hdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_pkt,
    input  logic       frame_done,
    input  logic       frame_tick,
    output logic [7:0] cur_seq,
    output logic       first_pkt,
    output logic [7:0] hdr_fcnt
);

    logic       new_frame;
    logic [7:0] seq_nxt;
    logic [7:0] frame_cnt;
    logic [7:0] seq_pick;

    assign seq_pick = new_frame ? 8'h00 : seq_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_frame <= 1'b1;
            seq_nxt   <= 8'h00;
            cur_seq   <= 8'h00;
            first_pkt <= 1'b0;
            frame_cnt <= 8'h00;
            hdr_fcnt  <= 8'h00;
        end else begin
            if (frame_tick) begin
                frame_cnt <= frame_cnt + 8'h01;
            end
            if (start_pkt) begin
                cur_seq   <= seq_pick;
                seq_nxt   <= (seq_pick == SEQ_LAST) ? 8'h00 : seq_pick + 8'h01;
                first_pkt <= new_frame;
                hdr_fcnt  <= frame_cnt;
                new_frame <= 1'b0;
            end else if (frame_done) begin
                new_frame <= 1'b1;
            end
        end
    end

    // R3: a packet opening a frame restarts the sequence
    assert_first_seq_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pkt && new_frame) |=> (cur_seq == 8'h00 && first_pkt));

    // R4: the drop marker never appears as a data sequence value
    assert_seq_not_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_pkt |=> (cur_seq != DROP_MARK));

    // R7: a finished frame makes the next packet a first packet
    assert_frame_reopen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !start_pkt) |=> new_frame);

endmodule

// File: rtl/iso_hdr_sel.sv
module iso_hdr_sel
    import iso_hdr_pkg::*;
(
    input  logic [3:0]              hdr_idx,
    input  logic [7:0]              cur_seq,
    input  logic [7:0]              hdr_fcnt,
    input  logic [PROP_BYTES*8-1:0] prop_info,
    output logic [7:0]              hdr_byte
);

    logic [7:0] hb [HDR_BYTES];

    assign hb[0] = cur_seq;
    assign hb[1] = prop_info[7:0] & PROP1_MASK;
    assign hb[6] = hdr_fcnt;

    for (genvar k = 2; k < HDR_BYTES; k++) begin : g_prop
        if (k < 6) begin : g_low
            assign hb[k] = prop_info[8*(k-1) +: 8];
        end else if (k > 6) begin : g_high
            assign hb[k] = prop_info[8*(k-2) +: 8];
        end
    end

    always_comb begin
        hdr_byte = 8'h00;
        for (int i = 0; i < HDR_BYTES; i++) begin
            if (hdr_idx == 4'(i)) begin
                hdr_byte = hb[i];
            end
        end
    end

endmodule

// File: rtl/iso_pkt_ctrl.sv
module iso_pkt_ctrl
    import iso_hdr_pkg::*;
#(
    parameter int FILL_W          = 12,
    parameter int DROP_THR_WIDE   = 4,
    parameter int DROP_THR_NARROW = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iso_en,
    input  logic              drop_block,
    input  logic              drop_thr_sel,
    input  logic [2:0]        alt_set,
    input  logic              pkt_req,
    input  logic [FILL_W-1:0] fifo_level,
    input  logic [7:0]        fifo_data,
    input  logic              fifo_last,
    input  logic              first_pkt,
    input  logic [7:0]        hdr_byte,
    output logic [3:0]        hdr_idx,
    output logic              start_pkt,
    output logic              frame_done,
    output logic              fifo_pop,
    output logic              pkt_valid,
    output logic [7:0]        pkt_byte,
    output logic              pkt_sop,
    output logic              pkt_eop,
    output logic              pkt_zlp
);

    localparam logic [FILL_W-1:0] THR_WIDE   = FILL_W'(DROP_THR_WIDE);
    localparam logic [FILL_W-1:0] THR_NARROW = FILL_W'(DROP_THR_NARROW);
    localparam logic [FILL_W-1:0] ONE_LEFT   = FILL_W'(1);
    localparam logic [3:0]        HDR_FULL   = 4'(HDR_BYTES - 1);

    pkt_state_t          state, nxt;
    logic [SIZE_W-1:0]   byte_cnt;
    logic [SIZE_W-1:0]   max_sz;
    logic                accept;
    logic                drop_cond;
    logic                hdr_done;
    logic                body_end;
    logic [3:0]          hdr_end;

    assign accept    = (state == ST_IDLE) && pkt_req && iso_en;
    assign drop_cond = !drop_block &&
                       (fifo_level <= (drop_thr_sel ? THR_NARROW : THR_WIDE));
    assign hdr_end   = first_pkt ? HDR_FULL : 4'd0;
    assign hdr_done  = (hdr_idx == hdr_end);
    assign body_end  = fifo_last || (byte_cnt == max_sz - SIZE_W'(1)) ||
                       (fifo_level == ONE_LEFT);
    assign start_pkt = accept && (alt_set != 3'd0) && !drop_cond;

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (alt_set == 3'd0) begin
                        nxt = ST_EMPTY;
                    end else if (drop_cond) begin
                        nxt = ST_DROP;
                    end else begin
                        nxt = ST_HDR;
                    end
                end
            end
            ST_HDR: begin
                if (hdr_done) begin
                    nxt = (fifo_level == '0) ? ST_IDLE : ST_BODY;
                end
            end
            ST_BODY: begin
                if (body_end) begin
                    nxt = ST_IDLE;
                end
            end
            ST_DROP:  nxt = ST_IDLE;
            ST_EMPTY: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // packet counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt <= '0;
            max_sz   <= '0;
            hdr_idx  <= '0;
        end else begin
            if (accept) begin
                max_sz <= alt_max_size(alt_set);
            end
            if (start_pkt) begin
                byte_cnt <= '0;
                hdr_idx  <= '0;
            end else if (state == ST_HDR) begin
                byte_cnt <= byte_cnt + SIZE_W'(1);
                hdr_idx  <= hdr_idx + 4'd1;
            end else if (state == ST_BODY) begin
                byte_cnt <= byte_cnt + SIZE_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        pkt_valid  = 1'b0;
        pkt_byte   = 8'h00;
        pkt_sop    = 1'b0;
        pkt_eop    = 1'b0;
        pkt_zlp    = 1'b0;
        fifo_pop   = 1'b0;
        frame_done = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_HDR: begin
                pkt_valid = 1'b1;
                pkt_byte  = hdr_byte;
                pkt_sop   = (hdr_idx == 4'd0);
                pkt_eop   = hdr_done && (fifo_level == '0);
            end
            ST_BODY: begin
                pkt_valid  = 1'b1;
                pkt_byte   = fifo_data;
                pkt_eop    = body_end;
                fifo_pop   = 1'b1;
                frame_done = fifo_last;
            end
            ST_DROP: begin
                pkt_valid = 1'b1;
                pkt_byte  = DROP_MARK;
                pkt_sop   = 1'b1;
                pkt_eop   = 1'b1;
            end
            ST_EMPTY: pkt_zlp = 1'b1;
            default: ;
        endcase
    end

    // R6: no data byte lies past the size limit
    assert_len_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR || state == ST_BODY) |-> (byte_cnt < max_sz));

    // R12: bytes are only taken from a non-empty FIFO
    assert_pop_nonempty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (fifo_level != '0));

    // R8: the zero-length response carries nothing
    assert_zlp_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_zlp |-> (!pkt_valid && !fifo_pop));

    // R4: a drop packet lasts one cycle
    assert_drop_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DROP) |=> (state == ST_IDLE));

    // R9: disabled block stays idle
    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !iso_en) |=> (state == ST_IDLE));

    // R11: an accepted request answers in the next cycle
    assert_answer_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (pkt_sop || pkt_zlp));

endmodule

// File: rtl/iso_pkt_hdr_gen.sv
module iso_pkt_hdr_gen
    import iso_hdr_pkg::*;
#(
    parameter int FILL_W          = 12,
    parameter int DROP_THR_WIDE   = 4,
    parameter int DROP_THR_NARROW = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iso_en,
    input  logic                    drop_block,
    input  logic                    drop_thr_sel,
    input  logic [2:0]              alt_set,
    input  logic                    pkt_req,
    input  logic                    frame_tick,
    input  logic [PROP_BYTES*8-1:0] prop_info,
    input  logic [FILL_W-1:0]       fifo_level,
    input  logic [7:0]              fifo_data,
    input  logic                    fifo_last,
    output logic                    fifo_pop,
    output logic                    pkt_valid,
    output logic [7:0]              pkt_byte,
    output logic                    pkt_sop,
    output logic                    pkt_eop,
    output logic                    pkt_zlp
);

    logic [3:0] hdr_idx;
    logic [7:0] hdr_byte;
    logic [7:0] cur_seq;
    logic [7:0] hdr_fcnt;
    logic       first_pkt;
    logic       start_pkt;
    logic       frame_done;

    iso_pkt_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_pkt  (start_pkt),
        .frame_done (frame_done),
        .frame_tick (frame_tick),
        .cur_seq    (cur_seq),
        .first_pkt  (first_pkt),
        .hdr_fcnt   (hdr_fcnt)
    );

    iso_hdr_sel u_sel (
        .hdr_idx   (hdr_idx),
        .cur_seq   (cur_seq),
        .hdr_fcnt  (hdr_fcnt),
        .prop_info (prop_info),
        .hdr_byte  (hdr_byte)
    );

    iso_pkt_ctrl #(
        .FILL_W          (FILL_W),
        .DROP_THR_WIDE   (DROP_THR_WIDE),
        .DROP_THR_NARROW (DROP_THR_NARROW)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .iso_en       (iso_en),
        .drop_block   (drop_block),
        .drop_thr_sel (drop_thr_sel),
        .alt_set      (alt_set),
        .pkt_req      (pkt_req),
        .fifo_level   (fifo_level),
        .fifo_data    (fifo_data),
        .fifo_last    (fifo_last),
        .first_pkt    (first_pkt),
        .hdr_byte     (hdr_byte),
        .hdr_idx      (hdr_idx),
        .start_pkt    (start_pkt),
        .frame_done   (frame_done),
        .fifo_pop     (fifo_pop),
        .pkt_valid    (pkt_valid),
        .pkt_byte     (pkt_byte),
        .pkt_sop      (pkt_sop),
        .pkt_eop      (pkt_eop),
        .pkt_zlp      (pkt_zlp)
    );

endmodule

// File: tb/iso_pkt_hdr_gen_test.sv
module iso_pkt_hdr_gen_test;

    localparam int FILL_W = 12;
    localparam int DEPTH  = 4096;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        iso_en, drop_block, drop_thr_sel, pkt_req, frame_tick;
    logic [2:0]  alt_set;
    logic [63:0] prop_info;
    logic [FILL_W-1:0] fifo_level;
    logic [7:0]  fifo_data;
    logic        fifo_last;
    logic        fifo_pop, pkt_valid, pkt_sop, pkt_eop, pkt_zlp;
    logic [7:0]  pkt_byte;

    always #2 clk = ~clk;

    iso_pkt_hdr_gen #(.FILL_W(FILL_W)) uut (
        .clk(clk), .rst_n(rst_n), .iso_en(iso_en), .drop_block(drop_block),
        .drop_thr_sel(drop_thr_sel), .alt_set(alt_set), .pkt_req(pkt_req),
        .frame_tick(frame_tick), .prop_info(prop_info), .fifo_level(fifo_level),
        .fifo_data(fifo_data), .fifo_last(fifo_last), .fifo_pop(fifo_pop),
        .pkt_valid(pkt_valid), .pkt_byte(pkt_byte), .pkt_sop(pkt_sop),
        .pkt_eop(pkt_eop), .pkt_zlp(pkt_zlp)
    );

    // bench FIFO
    logic [7:0]  fmem  [0:DEPTH-1];
    logic        flast [0:DEPTH-1];
    logic [31:0] wr_ptr, rd_ptr, m_rd;

    assign fifo_level = FILL_W'(wr_ptr - rd_ptr);
    assign fifo_data  = fmem[rd_ptr[11:0]];
    assign fifo_last  = flast[rd_ptr[11:0]];

    always @(posedge clk) begin
        if (rst_n && fifo_pop) rd_ptr <= rd_ptr + 32'd1;
    end

    // model state and counters
    bit         m_new;
    logic [7:0] m_seq, m_fcnt;
    int         n_chk = 0, n_bad = 0, n_wrap = 0, cyc_cnt = 0;
    logic [7:0] exp_b [0:1100];
    int         exp_n, exp_kind;
    bit         exp_first;
    string      exp_reason;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt == 195000) begin
            n_chk++; n_bad++;
            $display("FAIL R11 watchdog expired: got %0d cycles expected fewer", cyc_cnt);
            summary();
            $finish;
        end
    end

    function automatic int size_of(input logic [2:0] a);
        case (a)
            3'd0: return 0;    3'd1: return 128;  3'd2: return 384;  3'd3: return 512;
            3'd4: return 640;  3'd5: return 768;  3'd6: return 896;  default: return 1023;
        endcase
    endfunction

    function automatic logic [7:0] prop_byte(input int k);
        if (k == 1) return prop_info[7:0] & 8'hDF;
        if (k == 6) return m_fcnt;
        if (k < 6)  return prop_info[8*(k-1) +: 8];
        return prop_info[8*(k-2) +: 8];
    endfunction

    function automatic string byte_tag(input int idx);
        if (exp_kind == 2) return "R4";
        if (idx == 0) return "R3";
        if (exp_first) return (idx == 6) ? "R10" : "R1";
        return "R2";
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input int n, input bit ends);
        for (int i = 0; i < n; i++) begin
            fmem[wr_ptr[11:0]]  = 8'($urandom);
            flast[wr_ptr[11:0]] = ends && (i == n - 1);
            wr_ptr = wr_ptr + 32'd1;
        end
    endtask

    task automatic tick();
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        m_fcnt = m_fcnt + 8'd1;
    endtask

    // compute the expected packet from the state seen at the request
    task automatic predict();
        int lvl, maxs, thr;
        logic [7:0] s;
        lvl = int'(wr_ptr - m_rd);
        thr = drop_thr_sel ? 1 : 4;
        exp_n = 0; exp_first = 1'b0; exp_reason = "R12";
        if (!iso_en) begin
            exp_kind = 0;
        end else if (alt_set == 3'd0) begin
            exp_kind = 1;
        end else if (!drop_block && lvl <= thr) begin
            exp_kind = 2; exp_b[0] = 8'hFF; exp_n = 1;
        end else begin
            exp_kind = 3;
            maxs = size_of(alt_set);
            s = m_new ? 8'h00 : m_seq;
            if (!m_new && s == 8'h00) n_wrap++;
            m_seq = (s == 8'hFE) ? 8'h00 : s + 8'd1;
            exp_first = m_new;
            m_new = 1'b0;
            exp_b[exp_n++] = s;
            if (exp_first) for (int k = 1; k < 10; k++) exp_b[exp_n++] = prop_byte(k);
            while (exp_n < maxs && lvl > 0) begin
                exp_b[exp_n++] = fmem[m_rd[11:0]];
                lvl--;
                if (flast[m_rd[11:0]]) begin
                    m_rd = m_rd + 32'd1; m_new = 1'b1; exp_reason = "R7"; break;
                end
                m_rd = m_rd + 32'd1;
            end
            if (exp_n == maxs) exp_reason = "R6";
        end
    endtask

    task automatic run_pkt();
        int got;
        predict();
        pkt_req = 1'b1;
        @(negedge clk);
        pkt_req = 1'b0;
        got = 0;
        // first result is due in the cycle after the request edge
        chk(pkt_zlp == (exp_kind == 1), "R8", "zero-length pulse", pkt_zlp, exp_kind == 1);
        chk(pkt_valid == (exp_kind >= 2), (exp_kind == 0) ? "R9" : "R11",
            "first-cycle valid", pkt_valid, exp_kind >= 2);
        if (exp_kind == 0) begin
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                chk(!pkt_valid && !pkt_zlp && !fifo_pop, "R9", "disabled output",
                    pkt_valid | pkt_zlp | fifo_pop, 0);
            end
            return;
        end
        if (exp_kind == 1) begin
            chk(!fifo_pop, "R8", "no pop on zero-length", fifo_pop, 0);
        end else begin
            for (int c = 0; c < 1100; c++) begin
                if (c > 0) @(negedge clk);
                if (!pkt_valid) begin
                    chk(1'b0, "R11", "gap inside packet", got, exp_n);
                    break;
                end
                if (got == 0) chk(pkt_sop, "R11", "start marker", pkt_sop, 1);
                if (got < exp_n)
                    chk(pkt_byte == exp_b[got], byte_tag(got), "packet byte", pkt_byte, exp_b[got]);
                got++;
                if (pkt_eop) break;
                pkt_req = (c == 2);
            end
            pkt_req = 1'b0;
            chk(got == exp_n, (exp_kind == 2) ? "R4" : exp_reason, "packet length", got, exp_n);
        end
        @(negedge clk);
        chk(!pkt_valid && !pkt_zlp, "R11", "idle after packet", pkt_valid | pkt_zlp, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; iso_en = 1'b1; drop_block = 1'b0; drop_thr_sel = 1'b0;
        alt_set = 3'd1; pkt_req = 1'b0; frame_tick = 1'b0;
        prop_info = {$urandom, $urandom} | 64'h20;
        wr_ptr = 0; rd_ptr = 0; m_rd = 0; m_new = 1'b1; m_seq = 8'h00; m_fcnt = 8'h00;
        for (int i = 0; i < DEPTH; i++) begin fmem[i] = 8'h00; flast[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pkt_valid && !pkt_zlp && !fifo_pop, "R11", "reset state",
            pkt_valid | pkt_zlp | fifo_pop, 0);

        // drop thresholds, drain, frame end
        run_pkt();                              // level 0: drop (R4)
        push(4, 1'b0); run_pkt();               // level 4: drop (R4)
        push(1, 1'b0); run_pkt();               // level 5: header + 5 bytes (R12)
        tick();
        push(1, 1'b1); run_pkt();               // level 1: drop
        drop_thr_sel = 1'b1; run_pkt();         // level 1 narrow: drop
        push(3, 1'b1); run_pkt();               // level 4 narrow: ends on frame (R7)
        run_pkt();                              // new frame, 3 bytes (R7, R1)
        drop_block = 1'b1;
        run_pkt(); run_pkt();                   // empty FIFO: header only (R5)
        iso_en = 1'b0; run_pkt(); iso_en = 1'b1; // ignored (R9)
        alt_set = 3'd0; push(50, 1'b0); run_pkt(); // zero-length (R8)
        tick(); tick();
        for (int a = 1; a < 8; a++) begin       // every size (R6)
            alt_set = 3'(a);
            if (int'(wr_ptr - m_rd) < 1100) push(1100, 1'b0);
            run_pkt();
        end
        // sequence wrap inside one long frame (R3)
        alt_set = 3'd1;
        for (int p = 0; p < 258; p++) begin
            if (int'(wr_ptr - m_rd) < 300) push(600, 1'b0);
            run_pkt();
        end
        chk(n_wrap > 0, "R3", "sequence wrap seen", n_wrap, 1);
        push(1, 1'b1);

        // constrained random mix
        for (int p = 0; p < 90; p++) begin
            alt_set      = 3'($urandom_range(0, 7));
            iso_en       = ($urandom_range(0, 9) != 0);
            drop_block   = ($urandom_range(0, 3) == 0);
            drop_thr_sel = 1'($urandom);
            if ($urandom_range(0, 2) == 0) prop_info = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) tick();
            if (int'(wr_ptr - m_rd) < 1500 && $urandom_range(0, 1) == 1)
                push($urandom_range(1, 900), $urandom_range(0, 2) != 0);
            run_pkt();
        end

        summary();
        $finish;
    end

endmodule